// File: doc/BRIEF.md
# CAN Receive Buffer Status Tracker

This block keeps the four-bit status code of a single CAN receive message buffer. Software arms the buffer, the acceptance filter upstream strobes it when a matching frame is ready in the hidden receive buffer, and the block then shows a busy window while that frame is transferred into the buffer as one unit. After the transfer the code reports whether the buffer holds one unread frame or whether an unread frame was overwritten.

An optional lock freezes the buffer once it has taken a frame. Later frames are refused until software releases it, so a run of frames with the same identifier can be spread over several buffers. Software can sample the status through a registered read port. During a transfer that port returns the last settled code rather than the transient busy code. The data transfer itself is represented only by a busy window whose length is set on an input.

Top module: `can_rxbuf_status`

## Requirements
- R1: After reset the status reads 0000b, and busy, overrun and locked are all low.
- R2: Status bit 3 is the direction flag and is always 0. Bits 2:1 carry the state: 00 off, 01 empty, 10 full, 11 overrun. Bit 0 is the busy flag. The settled codes are therefore 0000b, 0010b, 0100b and 0110b.
- R3: An arm pulse while the buffer is off moves it to empty (0010b). An acceptance strobe while the buffer is off has no effect.
- R4: An acceptance strobe in the empty or full state, with the buffer unlocked and not busy, starts a transfer. From the next cycle, busy is high for copy_len cycles, with a copy_len of 0 treated as 1. During the transfer the status shows 0011b when it started from empty and 0101b when it started from full.
- R5: When a transfer ends, the buffer moves from empty to full (0100b) or from full to overrun (0110b). The overrun output is high exactly in the overrun state.
- R6: An acceptance strobe in the overrun state, or while busy, has no effect.
- R7: If lock_en is high when a transfer ends, the buffer becomes locked. A locked buffer ignores acceptance strobes.
- R8: A release pulse in the full or overrun state returns the buffer to empty and clears the lock. When a release and an acceptance strobe arrive in the same cycle, the release wins and no transfer starts.
- R9: An off pulse while not busy returns the buffer to off (0000b) from any state and clears the lock. It takes priority over release and arm.
- R10: Arm, release and off pulses that arrive while busy are ignored.
- R11: A read pulse loads rd_data on the next clock edge with the status code with its busy bit cleared. During a transfer this is the code from before the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_en | input | 1 | Lock the buffer after each stored frame |
| copy_len | input | LEN_W | Transfer window length in cycles (0 acts as 1) |
| arm_stb | input | 1 | Software pulse: enable reception |
| off_stb | input | 1 | Software pulse: disable reception |
| acc_stb | input | 1 | Frame accepted for this buffer by the filter |
| rel_stb | input | 1 | Software pulse: frame consumed, release buffer |
| rd_stb | input | 1 | Software status read |
| status | output | 4 | Live status code {dir, state[1:0], busy} |
| busy | output | 1 | Transfer window active |
| overrun | output | 1 | Buffer is in the overrun state |
| locked | output | 1 | Buffer is locked against new frames |
| rd_data | output | 4 | Registered status returned by the last read |

## Verification
If the state register is wrong, the settled code is wrong on status at the next falling edge after the edge that should have moved it. If the transfer counter is wrong, the busy window on status bit 0 is too long or too short, and the full or overrun code appears one or more cycles early or late. That timing is checked cycle by cycle for every window length swept. A lock or release fault only shows when the next strobe is accepted or refused, so every such fault is tested with a following acceptance strobe.

// File: rtl/can_rxbuf_pkg.sv
package can_rxbuf_pkg;

  typedef enum logic [1:0] {
    RXB_OFF   = 2'b00,
    RXB_EMPTY = 2'b01,
    RXB_FULL  = 2'b10,
    RXB_OVR   = 2'b11
  } rxb_state_e;

  // Status code: direction (0 for receive), state, busy
  function automatic logic [3:0] rxb_code(rxb_state_e s, logic bsy);
    return {1'b0, s, bsy};
  endfunction

  function automatic logic rxb_can_take(rxb_state_e s, logic lck);
    return !lck && (s == RXB_EMPTY || s == RXB_FULL);
  endfunction

  function automatic rxb_state_e rxb_after_store(rxb_state_e s);
    return (s == RXB_EMPTY) ? RXB_FULL : RXB_OVR;
  endfunction

endpackage

// File: rtl/rxb_copy_timer.sv
module rxb_copy_timer #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             done
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= (len == '0) ? ONE : len;
    else if (busy)
      cnt <= cnt - ONE;
  end
endmodule

// File: rtl/rxb_state_fsm.sv
module rxb_state_fsm
  import can_rxbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_stb,
  input  logic       arm_stb,
  input  logic       rel_stb,
  input  logic       off_stb,
  input  logic       lock_en,
  input  logic       busy,
  input  logic       done,
  output rxb_state_e state,
  output logic       locked,
  output logic       start
);
  logic idle;
  logic holds_frame;

  assign idle        = !busy;
  assign holds_frame = (state == RXB_FULL) || (state == RXB_OVR);
  assign start       = idle && acc_stb && !off_stb && !rel_stb &&
                       rxb_can_take(state, locked);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RXB_OFF;
      locked <= 1'b0;
    end else if (done) begin
      state <= rxb_after_store(state);
      if (lock_en) locked <= 1'b1;
    end else if (idle) begin
      if (off_stb) begin
        state  <= RXB_OFF;
        locked <= 1'b0;
      end else if (rel_stb && holds_frame) begin
        state  <= RXB_EMPTY;
        locked <= 1'b0;
      end else if (arm_stb && state == RXB_OFF) begin
        state <= RXB_EMPTY;
      end
    end
  end
endmodule

// File: rtl/rxb_read_port.sv
module rxb_read_port
  import can_rxbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb,
  input  rxb_state_e state,
  output logic [3:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= 4'b0000;
    else if (rd_stb)
      rd_data <= rxb_code(state, 1'b0);
  end
endmodule

// File: rtl/can_rxbuf_status.sv
module can_rxbuf_status
  import can_rxbuf_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_en,
  input  logic [LEN_W-1:0] copy_len,
  input  logic             arm_stb,
  input  logic             off_stb,
  input  logic             acc_stb,
  input  logic             rel_stb,
  input  logic             rd_stb,
  output logic [3:0]       status,
  output logic             busy,
  output logic             overrun,
  output logic             locked,
  output logic [3:0]       rd_data
);
  rxb_state_e state;
  logic       store_start;
  logic       store_done;

  rxb_copy_timer #(.LEN_W(LEN_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (store_start),
    .len   (copy_len),
    .busy  (busy),
    .done  (store_done)
  );

  rxb_state_fsm i_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_stb (acc_stb),
    .arm_stb (arm_stb),
    .rel_stb (rel_stb),
    .off_stb (off_stb),
    .lock_en (lock_en),
    .busy    (busy),
    .done    (store_done),
    .state   (state),
    .locked  (locked),
    .start   (store_start)
  );

  rxb_read_port i_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .state   (state),
    .rd_data (rd_data)
  );

  assign status  = rxb_code(state, busy);
  assign overrun = (state == RXB_OVR);
endmodule

// File: rtl/can_rxbuf_status_chk.sv
module can_rxbuf_status_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] copy_len,
  input logic             arm_stb,
  input logic             off_stb,
  input logic             acc_stb,
  input logic             rel_stb,
  input logic             rd_stb,
  input logic [3:0]       status,
  input logic             busy,
  input logic             overrun,
  input logic             locked,
  input logic [3:0]       rd_data,
  input logic             store_start
);
  logic [LEN_W:0] run_cnt;
  logic [LEN_W:0] exp_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      exp_len <= '0;
    end else begin
      run_cnt <= busy ? run_cnt + 1'b1 : '0;
      if (store_start)
        exp_len <= (copy_len == '0) ? (LEN_W+1)'(1) : {1'b0, copy_len};
    end
  end

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == exp_len));

  assert_start_from_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acc_stb));

  assert_overrun_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(status) == 4'b0101));

  assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !busy) |=> !busy);

  assert_release_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_stb && !off_stb && !busy && status[2]) |=> (status == 4'b0010 && !locked));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !acc_stb && !arm_stb && !rel_stb && !off_stb) |=> $stable(status));

  assert_read_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_data[0]);
endmodule

bind can_rxbuf_status can_rxbuf_status_chk #(.LEN_W(LEN_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .copy_len    (copy_len),
  .arm_stb     (arm_stb),
  .off_stb     (off_stb),
  .acc_stb     (acc_stb),
  .rel_stb     (rel_stb),
  .rd_stb      (rd_stb),
  .status      (status),
  .busy        (busy),
  .overrun     (overrun),
  .locked      (locked),
  .rd_data     (rd_data),
  .store_start (store_start)
);

// File: tb/test_can_rxbuf_status.sv
module test_can_rxbuf_status;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lock_en = 1'b0;
  logic [LEN_W-1:0] copy_len = '0;
  logic             arm_stb = 1'b0;
  logic             off_stb = 1'b0;
  logic             acc_stb = 1'b0;
  logic             rel_stb = 1'b0;
  logic             rd_stb = 1'b0;
  logic [3:0]       status;
  logic             busy;
  logic             overrun;
  logic             locked;
  logic [3:0]       rd_data;

  int checks = 0;
  int errors = 0;

  can_rxbuf_status #(.LEN_W(LEN_W)) i_can_rxbuf_status (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .copy_len(copy_len),
    .arm_stb(arm_stb), .off_stb(off_stb), .acc_stb(acc_stb),
    .rel_stb(rel_stb), .rd_stb(rd_stb), .status(status), .busy(busy),
    .overrun(overrun), .locked(locked), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (len=%0d lock=%0b) at %0t",
               tag, act, exp, copy_len, lock_en, $time);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int lk = 0; lk < 2; lk++) begin
      for (int ln = 0; ln < 4; ln++) begin
        int eff;
        eff = (ln == 0) ? 1 : ln;
        tick();
        rst_n = 1'b0; lock_en = lk[0]; copy_len = LEN_W'(ln);
        wait_n(2);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(status, 4'b0000, "R1 status");
        chk({3'b0, busy}, 4'd0, "R1 busy");
        chk({2'b0, overrun, locked}, 4'd0, "R1 overrun/locked");
        // R3 accept while off ignored
        acc_stb = 1'b1; tick(); acc_stb = 1'b0;
        chk(status, 4'b0000, "R3 accept while off");
        // R3 arm
        arm_stb = 1'b1; tick(); arm_stb = 1'b0;
        chk(status, 4'b0010, "R3 arm to empty");
        // R4 first transfer, release and read during busy (R10, R11)
        acc_stb = 1'b1; tick(); acc_stb = 1'b0;
        for (int k = 1; k <= eff; k++) begin
          chk(status, 4'b0011, "R4 busy from empty");
          if (k == 1) begin rel_stb = 1'b1; rd_stb = 1'b1; end
          tick();
          if (k == 1) begin
            rel_stb = 1'b0; rd_stb = 1'b0;
            chk(rd_data, 4'b0010, "R11 read during busy");
          end
        end
        chk(status, 4'b0100, "R2 R5 R10 full after transfer");
        chk({3'b0, locked}, {3'b0, lk[0]}, "R7 lock after store");
        // second frame
        acc_stb = 1'b1; tick(); acc_stb = 1'b0;
        if (lk[0]) begin
          chk(status, 4'b0100, "R7 locked ignores accept");
        end else begin
          for (int k = 1; k <= eff; k++) begin
            chk(status, 4'b0101, "R4 busy from full");
            tick();
          end
          chk(status, 4'b0110, "R2 R5 overrun code");
          chk({3'b0, overrun}, 4'd1, "R5 overrun output");
          acc_stb = 1'b1; tick(); acc_stb = 1'b0;
          chk(status, 4'b0110, "R6 accept in overrun ignored");
        end
        // R11 idle read
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk(rd_data, lk[0] ? 4'b0100 : 4'b0110, "R11 idle read");
        // R9 off clears lock
        off_stb = 1'b1; rel_stb = 1'b1; tick(); off_stb = 1'b0; rel_stb = 1'b0;
        chk(status, 4'b0000, "R9 off");
        chk({3'b0, locked}, 4'd0, "R9 lock cleared");
        acc_stb = 1'b1; tick(); acc_stb = 1'b0;
        chk(status, 4'b0000, "R9 R3 off ignores accept");
        // refill then accept+release same cycle (R8)
        arm_stb = 1'b1; tick(); arm_stb = 1'b0;
        acc_stb = 1'b1; tick(); acc_stb = 1'b0;
        chk(status, 4'b0011, "R4 refill busy");
        off_stb = 1'b1; tick(); off_stb = 1'b0;
        wait_n(eff);
        chk(status, 4'b0100, "R10 off during busy ignored");
        acc_stb = 1'b1; rel_stb = 1'b1; tick(); acc_stb = 1'b0; rel_stb = 1'b0;
        chk(status, 4'b0010, "R8 release wins over accept");
        chk({3'b0, locked}, 4'd0, "R8 lock cleared");
        tick();
        chk({3'b0, busy}, 4'd0, "R8 no transfer started");
      end
    end
    finish_run();
  end
endmodule